// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver Path

This block is the logical data path of a wide bidirectional bus transceiver. It sits between a side that uses ordinary three-state outputs (the A side) and a side that uses open-drain, wired-OR outputs (the B side). The word is split into independent halves; each half carries two directions, A-to-B and B-to-A. Every direction in every half has its own storage element and its own four controls: an active-low enable for storage, an active-high "open" level that makes the path transparent, a transfer clock, and an active-low drive enable.

The controls are synchronous strobes sampled by the core clock `clk`. A direction is transparent while its open level is high. While its enable is low, the storage follows the input during the open phase and keeps the last sampled word when open drops. With open low and the enable low, the storage loads the input on a rising edge of the transfer clock. With the enable high and open low, the storage holds whatever happens on the data or the transfer clock. The B side never drives a one: each bit is a drive-low request, and an external pull-up resolves the bus. Input data must be stable across the core-clock edge that precedes a falling open level.

Top module: `ubt_top`

## Requirements
- R1: While a direction's open input is 1, its output data equals its input data in the same cycle, whatever the storage enable and transfer clock are.
- R2: While open is 1 and the enable (active low) is 0, each core-clock edge stores the input word. After open falls, the output holds the word stored at the last core edge that saw open at 1.
- R3: With open 0 and enable 0, a transfer clock sampled 0 at one core edge and 1 at the next stores the input at that second edge. A clock held high, or a falling clock, stores nothing.
- R4: With open 0 and enable 1, the stored word does not change under transfer-clock edges or input changes. If open falls while the enable is 1, the output goes back to the word stored before.
- R5: With the A-to-B drive enable at 1 (inactive), every `b_drive_low` bit of that half is 0. With it at 0, `b_drive_low[i]` is 1 exactly when data bit i is 0, so the pulled-up bus reads the data.
- R6: With the B-to-A drive enable at 1, that half's `a_out_en` and `a_out` bits are all 0. With it at 0, `a_out_en` is all ones and `a_out` carries the B-to-A data.
- R7: Asynchronous active-low reset clears every stored word to zero. After reset, with open 0 and the drives enabled, the pulled-up B bus reads zero and `a_out` reads zero.
- R8: The controls of half h act only on bits [h*HALF_W +: HALF_W]. The other half's outputs do not change.
- R9: The B-to-A direction implements R1 to R4 with its own four controls, taking `b_in` as input.
- R10: A transfer clock held high through reset release is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all control strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_drv_n | input | HALVES | A-to-B drive enable per half, active low |
| ab_en_n | input | HALVES | A-to-B storage enable per half, active low |
| ab_open | input | HALVES | A-to-B transparent level per half, active high |
| ab_clk | input | HALVES | A-to-B transfer clock per half |
| ba_drv_n | input | HALVES | B-to-A drive enable per half, active low |
| ba_en_n | input | HALVES | B-to-A storage enable per half, active low |
| ba_open | input | HALVES | B-to-A transparent level per half, active high |
| ba_clk | input | HALVES | B-to-A transfer clock per half |
| a_in | input | HALVES*HALF_W | Data received from the A side |
| a_out | output | HALVES*HALF_W | Data driven onto the A side (0 when released) |
| a_out_en | output | HALVES*HALF_W | Per-bit three-state enable for the A side |
| b_in | input | HALVES*HALF_W | Data received from the B side |
| b_drive_low | output | HALVES*HALF_W | Per-bit pull-low request for the open-drain B side |

## Verification
The bench goes after the three places where a storage element that serves as both latch and flip-flop tends to break. The first is the word held when open falls: a design that captures one cycle late or early shows the next or previous word. The second is a transfer clock that stays high or falls: a level-sensitive load would keep overwriting the held word. The third is open falling while storage is disabled: a design that lets the transparent phase load the storage would keep the new word instead of reverting. It also holds the transfer clock high through reset, where a design that resets its edge history to zero would report a false load. It checks that one half's strobes never move the other half's bits, including the case where the other half sees the same transfer-clock edges with storage disabled.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // Operating mode of one storage element, decoded from its two levels.
    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,  // open, storage disabled: output bypasses, store keeps
        MODE_TRACK = 2'd1,  // open, storage enabled: store follows input
        MODE_EDGE  = 2'd2,  // closed, storage enabled: load on rising transfer clock
        MODE_HOLD  = 2'd3   // closed, storage disabled: everything inhibited
    } path_mode_e;

    function automatic path_mode_e decode_mode(input logic en_n, input logic open);
        path_mode_e m;
        if (open) begin
            m = en_n ? MODE_PASS : MODE_TRACK;
        end else begin
            m = en_n ? MODE_HOLD : MODE_EDGE;
        end
        return m;
    endfunction

endpackage

// File: rtl/ubt_path.sv
module ubt_path
    import ubt_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic         open,
    input  logic         xclk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] store;
        logic         xclk_prev;
    } path_state_t;

    path_state_t cur_q, nxt_d;
    path_mode_e  mode;
    logic        xclk_rise;

    always_comb begin
        mode      = decode_mode(en_n, open);
        xclk_rise = xclk & ~cur_q.xclk_prev;
        nxt_d           = cur_q;
        nxt_d.xclk_prev = xclk;
        unique case (mode)
            MODE_TRACK: nxt_d.store = din;
            MODE_EDGE:  if (xclk_rise) nxt_d.store = din;
            MODE_PASS,
            MODE_HOLD:  nxt_d.store = cur_q.store;
            default:    nxt_d.store = cur_q.store;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.store     <= '0;
            cur_q.xclk_prev <= 1'b1;   // a clock already high is not an edge
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dout = open ? din : cur_q.store;

    // R2: tracking phase stores the sampled input
    p_track_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (open && !en_n) |=> (cur_q.store == $past(din)));

    // R3: rising transfer clock loads when closed and enabled
    p_edge_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !en_n && xclk && !cur_q.xclk_prev) |=> (cur_q.store == $past(din)));

    // R3: no rising transfer clock means no load when closed
    p_no_edge_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !en_n && !(xclk && !cur_q.xclk_prev)) |=> $stable(cur_q.store));

    // R4: disabled storage never changes
    p_inhibit_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n) |=> $stable(cur_q.store));

endmodule

// File: rtl/ubt_half.sv
module ubt_half #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_drv_n,
    input  logic         ab_en_n,
    input  logic         ab_open,
    input  logic         ab_clk,
    input  logic         ba_drv_n,
    input  logic         ba_en_n,
    input  logic         ba_open,
    input  logic         ba_clk,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_out_en,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_drive_low
);

    logic [W-1:0] ab_data;
    logic [W-1:0] ba_data;

    ubt_path #(.W(W)) ab_path_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en_n (ab_en_n),
        .open (ab_open),
        .xclk (ab_clk),
        .din  (a_in),
        .dout (ab_data)
    );

    ubt_path #(.W(W)) ba_path_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en_n (ba_en_n),
        .open (ba_open),
        .xclk (ba_clk),
        .din  (b_in),
        .dout (ba_data)
    );

    // Open-drain side: only pull low, and only when driving is enabled.
    assign b_drive_low = ab_drv_n ? '0 : ~ab_data;

    // Three-state side: value forced to zero while released.
    assign a_out    = ba_drv_n ? '0 : ba_data;
    assign a_out_en = {W{~ba_drv_n}};

    // R1: transparent A-to-B reaches the B pins unchanged
    p_ab_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_open && !ab_drv_n) |-> (b_drive_low == ~a_in));

    // R9: transparent B-to-A reaches the A pins unchanged
    p_ba_transparent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_open && !ba_drv_n) |-> (a_out == b_in));

    // R5: released B side pulls nothing low
    p_b_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ab_drv_n |-> (b_drive_low == '0));

    // R6: released A side is idle
    p_a_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ba_drv_n |-> (a_out_en == '0 && a_out == '0));

endmodule

// File: rtl/ubt_top.sv
module ubt_top #(
    parameter int HALVES = 2,
    parameter int HALF_W = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [HALVES-1:0]          ab_drv_n,
    input  logic [HALVES-1:0]          ab_en_n,
    input  logic [HALVES-1:0]          ab_open,
    input  logic [HALVES-1:0]          ab_clk,
    input  logic [HALVES-1:0]          ba_drv_n,
    input  logic [HALVES-1:0]          ba_en_n,
    input  logic [HALVES-1:0]          ba_open,
    input  logic [HALVES-1:0]          ba_clk,
    input  logic [HALVES*HALF_W-1:0]   a_in,
    output logic [HALVES*HALF_W-1:0]   a_out,
    output logic [HALVES*HALF_W-1:0]   a_out_en,
    input  logic [HALVES*HALF_W-1:0]   b_in,
    output logic [HALVES*HALF_W-1:0]   b_drive_low
);

    localparam int W = HALVES * HALF_W;

    logic [W-1:0] a_out_w;
    logic [W-1:0] a_out_en_w;
    logic [W-1:0] b_drive_low_w;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ubt_half #(.W(HALF_W)) half_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ab_drv_n   (ab_drv_n[h]),
            .ab_en_n    (ab_en_n[h]),
            .ab_open    (ab_open[h]),
            .ab_clk     (ab_clk[h]),
            .ba_drv_n   (ba_drv_n[h]),
            .ba_en_n    (ba_en_n[h]),
            .ba_open    (ba_open[h]),
            .ba_clk     (ba_clk[h]),
            .a_in       (a_in[h*HALF_W +: HALF_W]),
            .a_out      (a_out_w[h*HALF_W +: HALF_W]),
            .a_out_en   (a_out_en_w[h*HALF_W +: HALF_W]),
            .b_in       (b_in[h*HALF_W +: HALF_W]),
            .b_drive_low(b_drive_low_w[h*HALF_W +: HALF_W])
        );
    end

    assign a_out       = a_out_w;
    assign a_out_en    = a_out_en_w;
    assign b_drive_low = b_drive_low_w;

endmodule

// File: tb/ubt_top_tb_top.sv
`timescale 1ns/1ps
module ubt_top_tb_top;

    localparam int HALVES = 2;
    localparam int HALF_W = 18;
    localparam int W      = HALVES * HALF_W;
    localparam int NSTEP  = 16;

    // Entry: {en_n, open, xclk, drv_n, din[17:0], expected B bus[17:0]} for half 0 A-to-B
    localparam logic [39:0] VEC [NSTEP] = '{
        {4'b0100, 18'h12345, 18'h12345},  // R1 transparent
        {4'b0100, 18'h2AAAA, 18'h2AAAA},  // R1/R2 tracking
        {4'b0000, 18'h3FFFF, 18'h2AAAA},  // R2 held after open falls
        {4'b0010, 18'h3FFFF, 18'h3FFFF},  // R3 rising clock loads
        {4'b0010, 18'h00F0F, 18'h3FFFF},  // R3 clock held high
        {4'b0000, 18'h00F0F, 18'h3FFFF},  // R3 falling clock
        {4'b1010, 18'h00F0F, 18'h3FFFF},  // R4 inhibited edge
        {4'b1000, 18'h11111, 18'h3FFFF},  // R4 input change ignored
        {4'b1100, 18'h11111, 18'h11111},  // R1 transparent with enable high
        {4'b1000, 18'h11111, 18'h3FFFF},  // R4 reverts to older word
        {4'b0011, 18'h15555, 18'h3FFFF},  // R5 released, bus pulled up
        {4'b0010, 18'h00000, 18'h15555},  // R5 drive again, shows loaded word
        {4'b0110, 18'h0ABCD, 18'h0ABCD},  // R1 transparent
        {4'b0010, 18'h00001, 18'h0ABCD},  // R2 held, clock stayed high
        {4'b0000, 18'h00001, 18'h0ABCD},  // R3 falling clock
        {4'b0010, 18'h00001, 18'h00001}   // R3 rising clock loads
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [HALVES-1:0] ab_drv_n, ab_en_n, ab_open, ab_clk;
    logic [HALVES-1:0] ba_drv_n, ba_en_n, ba_open, ba_clk;
    logic [W-1:0]      a_in, b_in;
    logic [W-1:0]      a_out, a_out_en, b_drive_low;
    logic [W-1:0]      b_bus;

    int  n_run  = 0;
    int  n_fail = 0;
    logic done  = 1'b0;

    always #2.5 clk = ~clk;

    ubt_top #(.HALVES(HALVES), .HALF_W(HALF_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ab_drv_n(ab_drv_n), .ab_en_n(ab_en_n), .ab_open(ab_open), .ab_clk(ab_clk),
        .ba_drv_n(ba_drv_n), .ba_en_n(ba_en_n), .ba_open(ba_open), .ba_clk(ba_clk),
        .a_in(a_in), .a_out(a_out), .a_out_en(a_out_en),
        .b_in(b_in), .b_drive_low(b_drive_low)
    );

    // Pull-up resolution of the open-drain side
    assign b_bus = ~b_drive_low;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        ab_drv_n = '0; ab_en_n = 2'b10; ab_open = '0; ab_clk = '1;
        ba_drv_n = '0; ba_en_n = '1;    ba_open = '0; ba_clk = '0;
        a_in     = '1; b_in    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 / R10: cleared store, held-high clock not an edge
        check("R10 no false edge, B bus", b_bus, '0);
        check("R7 A data after reset", a_out, '0);
        check("R7 A enables after reset", a_out_en, '1);

        // Table walk: half 0 A-to-B follows the table, half 1 sees the same clock with storage off
        for (int i = 0; i < NSTEP; i++) begin
            ab_en_n  = {1'b1, VEC[i][39]};
            ab_open  = {1'b0, VEC[i][38]};
            ab_clk   = {VEC[i][37], VEC[i][37]};
            ab_drv_n = {1'b0, VEC[i][36]};
            a_in     = {~VEC[i][35:18], VEC[i][35:18]};
            @(negedge clk);
            check($sformatf("R1-5 step %0d half0", i), {18'h0, b_bus[17:0]}, {18'h0, VEC[i][17:0]});
            check($sformatf("R8 step %0d half1", i), {18'h0, b_bus[35:18]}, '0);
        end

        // Directed B-to-A on half 1 (R9), half 0 must not move (R8)
        ba_en_n = 2'b01; ba_open = 2'b10;
        b_in    = {18'h2B3C4, 18'h3FFFF};
        @(negedge clk);
        check("R9 B-to-A transparent", a_out[35:18], 36'h2B3C4);
        ba_open = 2'b00;
        b_in    = {18'h00055, 18'h3FFFF};
        @(negedge clk);
        check("R9 B-to-A held after open falls", a_out[35:18], 36'h2B3C4);
        ba_clk = 2'b11;
        @(negedge clk);
        check("R9 B-to-A rising clock loads", a_out[35:18], 36'h00055);
        check("R8 half0 A data untouched", a_out[17:0], '0);
        ba_drv_n = 2'b10;
        @(negedge clk);
        check("R6 released A enables", a_out_en, {18'h0, 18'h3FFFF});
        check("R6 released A data", a_out, '0);
        ba_drv_n = 2'b00;
        @(negedge clk);
        check("R6 re-enabled A data", a_out, {18'h00055, 18'h0});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule